// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block keeps a small, fully associative set of recent page translations for a memory management unit. Every entry holds a virtual page number, a physical frame number, three access-permission bits, a large-page flag and the identifier of the address-space context that installed it. A lookup searches all entries in parallel against the requested page and the currently active context. One clock later it reports either a hit, with the frame number and a protection-fault flag, or a miss, with the page number that a table walker must fetch.

When the walker returns, its result is installed through the refill port under the active context. Because entries are tagged, changing the active context does not discard anything: translations of a suspended context stay resident and hit again when that context becomes active. Large entries cover 512 consecutive virtual pages and share the array with ordinary 4 KB entries. Stale state is removed in one of three ways: a flush of the whole array, a flush of one context, or the removal of the single page that covers a given address.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid, `hit`, `permFault` and `missReq` are low, and the first lookup misses.
- R2: A lookup presented in clock cycle N that matches a valid entry raises `hit` in cycle N+1. `hitPfn` then holds the stored frame number, and `missReq` stays low.
- R3: A lookup that matches no entry raises `missReq` for one cycle in cycle N+1, with `missVpn` equal to the requested page, and keeps `hit` low. A cycle without a lookup leaves both `hit` and `missReq` low.
- R4: A refill installs its page, frame and permissions tagged with the context that is active in that cycle. A later lookup of that page in that context hits.
- R5: A lookup hits only an entry whose context tag equals the active context. Loading a new active context (`ctxSetValid`) keeps the entries of other contexts, and they hit again when their context is restored.
- R6: `flushAll` invalidates every entry, whatever its context. A refill presented in the same cycle is dropped.
- R7: `flushCtx` invalidates exactly the entries whose tag equals `flushCtxId`, even when that is not the active context. Other contexts keep their entries.
- R8: `invalValid` removes the entry of the active context whose page covers `invalVpn`, and leaves every other entry in place.
- R9: For an entry with the large flag set, the compare ignores the low 9 bits of the page number. The returned frame takes its low 9 bits from the looked-up page number and its remaining bits from the stored frame.
- R10: On a hit, `permFault` is 1 exactly when the access is a write to an entry that is not writable, a user access to an entry that is not user-accessible, or an instruction fetch from an entry marked no-execute. `hit` and `hitPfn` are still reported when `permFault` is 1.
- R11: A refill goes into the lowest-numbered invalid entry. When every entry is valid, it replaces the entry at a round-robin pointer that starts at entry 0 and advances by one on each such replacement.
- R12: When a refill and an invalidate whose address falls inside the refilled page arrive in the same cycle, the invalidate wins and the refill is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctxSetValid | input | 1 | Load a new active context |
| ctxSetId | input | CTX_W | Context identifier to make active |
| lookupValid | input | 1 | Translation request |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| lookupWrite | input | 1 | Request is a store |
| lookupUser | input | 1 | Request comes from user mode |
| lookupExec | input | 1 | Request is an instruction fetch |
| hit | output | 1 | Translation found (one cycle after request) |
| hitPfn | output | PFN_W | Translated physical frame number |
| permFault | output | 1 | Hit, but the access breaks a permission |
| missReq | output | 1 | No translation, walk required |
| missVpn | output | VPN_W | Page number the walker must resolve |
| refillValid | input | 1 | Install a walker result |
| refillVpn | input | VPN_W | Page number of the new entry |
| refillPfn | input | PFN_W | Frame number of the new entry |
| refillLarge | input | 1 | Entry covers a 512-page (2 MB) region |
| refillWritable | input | 1 | Stores are permitted |
| refillUserOk | input | 1 | User-mode access is permitted |
| refillNoExec | input | 1 | Instruction fetch is forbidden |
| invalValid | input | 1 | Remove the entry covering `invalVpn` |
| invalVpn | input | VPN_W | Page number to remove |
| flushAll | input | 1 | Invalidate every entry |
| flushCtx | input | 1 | Invalidate the entries of one context |
| flushCtxId | input | CTX_W | Context to flush |

## Verification
The checker watches the lookup handshake on every cycle. Each request resolves one cycle later into exactly one of hit or miss, idle cycles stay quiet, and a miss reports the page that was asked for. It also checks that a fault never appears without a hit, and that no hit is reported for a lookup made after a full flush. The contents of the array can only be observed through sequences of refills and lookups, so only the bench's scenarios can show the following: which permission combinations fault, how large pages are masked, whether entries survive a context switch, the reach of context and single-page invalidation, the choice of victim entry, and the outcome when a refill and an invalidate collide.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Index width able to address the largest supported array (128 entries)
  localparam int IDX_MAX_W   = 7;
  // Page-number bits ignored by a large-page compare
  localparam int LARGE_SHIFT = 9;

  typedef struct packed {
    logic                 refillEn;
    logic [IDX_MAX_W-1:0] refillIdx;
    logic                 flushAll;
    logic                 flushCtx;
    logic                 inval;
  } tlbStrobes_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int CTX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctxSetValid,
  input  logic [CTX_W-1:0]   ctxSetId,
  input  logic               refillValid,
  input  logic [VPN_W-1:0]   refillVpn,
  input  logic               refillLarge,
  input  logic               invalValid,
  input  logic [VPN_W-1:0]   invalVpn,
  input  logic               flushAll,
  input  logic               flushCtx,
  input  logic [ENTRIES-1:0] validVec,
  output logic [CTX_W-1:0]   activeCtx,
  output tlbStrobes_t        strb
);
  localparam logic [VPN_W-1:0] LARGE_MASK = ~VPN_W'((1 << LARGE_SHIFT) - 1);
  localparam logic [IDX_MAX_W-1:0] LAST_IDX = IDX_MAX_W'(ENTRIES - 1);

  logic [IDX_MAX_W-1:0] rrPtr;
  logic [IDX_MAX_W-1:0] freeIdx;
  logic                 anyFree;
  logic [VPN_W-1:0]     refMask;
  logic                 collide;

  // lowest-numbered invalid entry
  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_MAX_W'(i);
      end
    end
  end

  assign refMask = refillLarge ? LARGE_MASK : '1;
  assign collide = invalValid && (((refillVpn ^ invalVpn) & refMask) == '0);

  always_comb begin
    strb.refillEn  = refillValid && !flushAll && !collide;
    strb.refillIdx = anyFree ? freeIdx : rrPtr;
    strb.flushAll  = flushAll;
    strb.flushCtx  = flushCtx;
    strb.inval     = invalValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr     <= '0;
      activeCtx <= '0;
    end else begin
      if (ctxSetValid) activeCtx <= ctxSetId;
      if (strb.refillEn && !anyFree)
        rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_data.sv
module tlb_data
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int CTX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobes_t        strb,
  input  logic [CTX_W-1:0]   activeCtx,
  input  logic [CTX_W-1:0]   flushCtxId,
  input  logic [VPN_W-1:0]   invalVpn,
  input  logic [VPN_W-1:0]   refillVpn,
  input  logic [PFN_W-1:0]   refillPfn,
  input  logic               refillLarge,
  input  logic               refillWritable,
  input  logic               refillUserOk,
  input  logic               refillNoExec,
  input  logic               lookupValid,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic               lookupWrite,
  input  logic               lookupUser,
  input  logic               lookupExec,
  output logic [ENTRIES-1:0] validVec,
  output logic               hit,
  output logic [PFN_W-1:0]   hitPfn,
  output logic               permFault,
  output logic               missReq,
  output logic [VPN_W-1:0]   missVpn
);
  localparam logic [VPN_W-1:0] LARGE_MASK = ~VPN_W'((1 << LARGE_SHIFT) - 1);
  localparam logic [PFN_W-1:0] PFN_LOW    = PFN_W'((1 << LARGE_SHIFT) - 1);

  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   vpnQ   [ENTRIES];
  logic [PFN_W-1:0]   pfnQ   [ENTRIES];
  logic [CTX_W-1:0]   ctxQ   [ENTRIES];
  logic [ENTRIES-1:0] largeQ, wrQ, usrQ, nxQ;
  logic [ENTRIES-1:0] lkMatch, invMatch;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic [VPN_W-1:0] cmpMask;
    logic             ownCtx;
    logic             writeMe;
    assign cmpMask     = largeQ[i] ? LARGE_MASK : '1;
    assign ownCtx      = validQ[i] && (ctxQ[i] == activeCtx);
    assign lkMatch[i]  = ownCtx && (((vpnQ[i] ^ lookupVpn) & cmpMask) == '0);
    assign invMatch[i] = ownCtx && (((vpnQ[i] ^ invalVpn) & cmpMask) == '0);
    assign writeMe     = strb.refillEn && (strb.refillIdx == IDX_MAX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) validQ[i] <= 1'b0;
      else if (strb.flushAll) validQ[i] <= 1'b0;
      else if (writeMe) validQ[i] <= 1'b1;
      else if ((strb.flushCtx && ctxQ[i] == flushCtxId) || (strb.inval && invMatch[i]))
        validQ[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (writeMe) begin
        vpnQ[i]   <= refillVpn;
        pfnQ[i]   <= refillPfn;
        ctxQ[i]   <= activeCtx;
        largeQ[i] <= refillLarge;
        wrQ[i]    <= refillWritable;
        usrQ[i]   <= refillUserOk;
        nxQ[i]    <= refillNoExec;
      end
    end
  end

  assign validVec = validQ;

  logic             anyHit, selLarge, selWr, selUsr, selNx;
  logic [PFN_W-1:0] selPfn, outPfn;
  logic             violate;

  always_comb begin
    anyHit = 1'b0; selPfn = '0; selLarge = 1'b0;
    selWr = 1'b0; selUsr = 1'b0; selNx = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        anyHit = 1'b1; selPfn = pfnQ[i]; selLarge = largeQ[i];
        selWr = wrQ[i]; selUsr = usrQ[i]; selNx = nxQ[i];
      end
    end
  end

  assign outPfn  = selLarge ? ((selPfn & ~PFN_LOW) | PFN_W'(lookupVpn[LARGE_SHIFT-1:0]))
                            : selPfn;
  assign violate = (lookupWrite && !selWr) || (lookupUser && !selUsr) || (lookupExec && selNx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit <= 1'b0; hitPfn <= '0; permFault <= 1'b0; missReq <= 1'b0; missVpn <= '0;
    end else begin
      hit       <= lookupValid && anyHit;
      permFault <= lookupValid && anyHit && violate;
      missReq   <= lookupValid && !anyHit;
      hitPfn    <= (lookupValid && anyHit) ? outPfn : '0;
      if (lookupValid) missVpn <= lookupVpn;
    end
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int CTX_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctxSetValid,
  input  logic [CTX_W-1:0] ctxSetId,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic             lookupWrite,
  input  logic             lookupUser,
  input  logic             lookupExec,
  output logic             hit,
  output logic [PFN_W-1:0] hitPfn,
  output logic             permFault,
  output logic             missReq,
  output logic [VPN_W-1:0] missVpn,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PFN_W-1:0] refillPfn,
  input  logic             refillLarge,
  input  logic             refillWritable,
  input  logic             refillUserOk,
  input  logic             refillNoExec,
  input  logic             invalValid,
  input  logic [VPN_W-1:0] invalVpn,
  input  logic             flushAll,
  input  logic             flushCtx,
  input  logic [CTX_W-1:0] flushCtxId
);
  tlbStrobes_t        strb;
  logic [CTX_W-1:0]   activeCtx;
  logic [ENTRIES-1:0] validVec;

  tlb_ctrl #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctxSetValid(ctxSetValid), .ctxSetId(ctxSetId),
    .refillValid(refillValid), .refillVpn(refillVpn), .refillLarge(refillLarge),
    .invalValid(invalValid), .invalVpn(invalVpn), .flushAll(flushAll),
    .flushCtx(flushCtx), .validVec(validVec), .activeCtx(activeCtx), .strb(strb)
  );

  tlb_data #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .CTX_W(CTX_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .activeCtx(activeCtx), .flushCtxId(flushCtxId),
    .invalVpn(invalVpn), .refillVpn(refillVpn), .refillPfn(refillPfn),
    .refillLarge(refillLarge), .refillWritable(refillWritable),
    .refillUserOk(refillUserOk), .refillNoExec(refillNoExec),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn), .lookupWrite(lookupWrite),
    .lookupUser(lookupUser), .lookupExec(lookupExec), .validVec(validVec),
    .hit(hit), .hitPfn(hitPfn), .permFault(permFault), .missReq(missReq),
    .missVpn(missVpn)
  );
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic [VPN_W-1:0] lookupVpn,
  input logic             flushAll,
  input logic             hit,
  input logic             permFault,
  input logic             missReq,
  input logic [VPN_W-1:0] missVpn
);
  // R2
  lookup_resolves_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (hit ^ missReq));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> (!hit && !missReq));

  // R3
  miss_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    missReq |-> (missVpn == $past(lookupVpn)));

  // R10
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    permFault |-> hit);

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> ##1 !hit);
endmodule

bind ctx_tlb ctx_tlb_chk #(.VPN_W(VPN_W)) u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
  .flushAll(flushAll), .hit(hit), .permFault(permFault), .missReq(missReq),
  .missVpn(missVpn)
);

// File: tb/test_ctx_tlb.sv
module test_ctx_tlb;
  localparam int ENTRIES = 64;
  localparam int VPN_W = 20;
  localparam int PFN_W = 16;
  localparam int CTX_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctxSetValid = 0; logic [CTX_W-1:0] ctxSetId = '0;
  logic lookupValid = 0; logic [VPN_W-1:0] lookupVpn = '0;
  logic lookupWrite = 0, lookupUser = 0, lookupExec = 0;
  logic hit, permFault, missReq;
  logic [PFN_W-1:0] hitPfn;
  logic [VPN_W-1:0] missVpn;
  logic refillValid = 0; logic [VPN_W-1:0] refillVpn = '0; logic [PFN_W-1:0] refillPfn = '0;
  logic refillLarge = 0, refillWritable = 0, refillUserOk = 0, refillNoExec = 0;
  logic invalValid = 0; logic [VPN_W-1:0] invalVpn = '0;
  logic flushAll = 0, flushCtx = 0; logic [CTX_W-1:0] flushCtxId = '0;

  always #2.5 clk = ~clk;

  ctx_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .CTX_W(CTX_W)) i_ctx_tlb (.*);

  int total = 0;
  int bad = 0;
  logic sHit, sFault, sMiss;
  logic [PFN_W-1:0] sPfn;
  logic [VPN_W-1:0] sMissVpn;

  typedef struct packed {
    logic [19:0] vpn;
    logic w, u, x, eHit;
    logic [15:0] ePfn;
    logic eFault;
  } vec_t;

  // lookups in context 1 against the entries installed before the walk
  localparam vec_t VEC [10] = '{
    '{20'h00010, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0A00, 1'b0},  // R2 plain hit
    '{20'h00020, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0B00, 1'b0},  // R10 read of read-only
    '{20'h00020, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0B00, 1'b1},  // R10 write to read-only
    '{20'h00020, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0B00, 1'b1},  // R10 fetch from no-exec
    '{20'h00030, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0C00, 1'b1},  // R10 user on supervisor page
    '{20'h00030, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0C00, 1'b0},  // R10 supervisor write
    '{20'h00455, 1'b0, 1'b1, 1'b0, 1'b1, 16'h1255, 1'b0},  // R9 inside large page
    '{20'h005FF, 1'b0, 1'b1, 1'b0, 1'b1, 16'h13FF, 1'b0},  // R9 last page of region
    '{20'h00600, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0},  // R3 just past region
    '{20'h00011, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0}   // R3 neighbour page
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input logic w, input logic u, input logic x);
    @(negedge clk);
    lookupValid = 1; lookupVpn = v; lookupWrite = w; lookupUser = u; lookupExec = x;
    @(negedge clk);
    lookupValid = 0;
    sHit = hit; sPfn = hitPfn; sFault = permFault; sMiss = missReq; sMissVpn = missVpn;
  endtask

  task automatic refill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                        input logic lg, input logic w, input logic u, input logic nx);
    @(negedge clk);
    refillValid = 1; refillVpn = v; refillPfn = p; refillLarge = lg;
    refillWritable = w; refillUserOk = u; refillNoExec = nx;
    @(negedge clk);
    refillValid = 0;
  endtask

  task automatic setCtx(input logic [CTX_W-1:0] c);
    @(negedge clk); ctxSetValid = 1; ctxSetId = c;
    @(negedge clk); ctxSetValid = 0;
  endtask

  task automatic expectHit(input string req, input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p);
    lookup(v, 1'b0, 1'b0, 1'b0);
    chk(req, "hit", 32'(sHit), 32'd1);
    chk(req, "pfn", 32'(sPfn), 32'(p));
  endtask

  task automatic expectMiss(input string req, input logic [VPN_W-1:0] v);
    lookup(v, 1'b0, 1'b0, 1'b0);
    chk(req, "miss", 32'(sMiss), 32'd1);
    chk(req, "hit", 32'(sHit), 32'd0);
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "hit", 32'(hit), 32'd0);
    chk("R1", "missReq", 32'(missReq), 32'd0);
    chk("R1", "permFault", 32'(permFault), 32'd0);
    rstN = 1;
    expectMiss("R1", 20'h00010);
    chk("R3", "missVpn", 32'(sMissVpn), 32'h00010);
    @(negedge clk);
    chk("R3", "idle missReq", 32'(missReq), 32'd0);

    // R4 install in context 1
    setCtx(4'd1);
    refill(20'h00010, 16'h0A00, 1'b0, 1'b1, 1'b1, 1'b0);
    refill(20'h00020, 16'h0B00, 1'b0, 1'b0, 1'b1, 1'b1);
    refill(20'h00030, 16'h0C00, 1'b0, 1'b1, 1'b0, 1'b0);
    refill(20'h00400, 16'h1200, 1'b1, 1'b1, 1'b1, 1'b0);

    for (int k = 0; k < 10; k++) begin
      lookup(VEC[k].vpn, VEC[k].w, VEC[k].u, VEC[k].x);
      chk($sformatf("R2/R10 vec%0d", k), "hit", 32'(sHit), 32'(VEC[k].eHit));
      chk($sformatf("R3 vec%0d", k), "miss", 32'(sMiss), 32'(!VEC[k].eHit));
      chk($sformatf("R9 vec%0d", k), "pfn", 32'(sPfn), 32'(VEC[k].ePfn));
      chk($sformatf("R10 vec%0d", k), "fault", 32'(sFault), 32'(VEC[k].eFault));
    end

    // R5 context isolation and retention
    setCtx(4'd2);
    expectMiss("R5", 20'h00010);
    refill(20'h00010, 16'h0D00, 1'b0, 1'b1, 1'b1, 1'b0);
    expectHit("R4", 20'h00010, 16'h0D00);
    setCtx(4'd1);
    expectHit("R5", 20'h00010, 16'h0A00);

    // R7 flush of a non-active context
    @(negedge clk); flushCtx = 1; flushCtxId = 4'd2;
    @(negedge clk); flushCtx = 0;
    expectHit("R7", 20'h00010, 16'h0A00);
    setCtx(4'd2);
    expectMiss("R7", 20'h00010);
    setCtx(4'd1);

    // R8 single-page removal through a large entry
    @(negedge clk); invalValid = 1; invalVpn = 20'h00456;
    @(negedge clk); invalValid = 0;
    expectMiss("R8", 20'h00455);
    expectHit("R8", 20'h00010, 16'h0A00);

    // R12 same-cycle refill and invalidate
    @(negedge clk);
    refillValid = 1; refillVpn = 20'h00070; refillPfn = 16'h0E00; refillLarge = 0;
    refillWritable = 1; refillUserOk = 1; refillNoExec = 0;
    invalValid = 1; invalVpn = 20'h00070;
    @(negedge clk); refillValid = 0; invalValid = 0;
    expectMiss("R12", 20'h00070);
    refill(20'h00070, 16'h0E00, 1'b0, 1'b1, 1'b1, 1'b0);
    expectHit("R12", 20'h00070, 16'h0E00);

    // R6 full flush, refill in same cycle dropped
    @(negedge clk);
    flushAll = 1; refillValid = 1; refillVpn = 20'h00080; refillPfn = 16'h0F00;
    @(negedge clk); flushAll = 0; refillValid = 0;
    expectMiss("R6", 20'h00010);
    expectMiss("R6", 20'h00080);

    // R11 fill every entry, then round-robin replacement from entry 0
    for (int i = 0; i < ENTRIES; i++)
      refill(20'h00100 + VPN_W'(i), PFN_W'(i), 1'b0, 1'b1, 1'b1, 1'b0);
    expectHit("R11", 20'h0013F, 16'h003F);
    refill(20'h00900, 16'h0900, 1'b0, 1'b1, 1'b1, 1'b0);
    expectMiss("R11", 20'h00100);
    expectHit("R11", 20'h00101, 16'h0001);
    expectHit("R11", 20'h00900, 16'h0900);
    refill(20'h00901, 16'h0901, 1'b0, 1'b1, 1'b1, 1'b0);
    expectMiss("R11", 20'h00101);
    expectHit("R11", 20'h00102, 16'h0002);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule